// File: doc/BRIEF.md
# Motion-Estimation Coprocessor Host Port

This block is the outside face of a programmable motion-estimation coprocessor. A single narrow data port, a wide address port and a request/grant pair to an external arbiter serve two separate jobs. First, the host loads the coprocessor's program. Second, the coprocessor hands back the motion vector it has computed. Both jobs go through the same 8-bit bidirectional data lane and the same 20-bit address lane. The block drives either lane only while it holds the bus and is emitting a result.

Loading starts when reset and enable are high together. The block then requests the bus and accepts one byte per granted, valid cycle into a 2 KB program store. The byte address comes from the host on the address lane. Each 16-bit instruction is built from two bytes, with the lower address holding the low byte. Loading ends by itself once the top byte location has been written. The processor core reads finished instructions through a separate synchronous read port.

When the core presents a result, the block latches it and raises its request. After it sees the grant, it places the horizontal byte and then the vertical byte on the data lane in two back-to-back cycles. It flips a marker line with each byte.

Flow control works like this. A load byte moves only in a cycle where grant and the host's byte-valid are both high, so either one low stalls the load. A result waits, with request held high, for as many cycles as grant stays low. Once the first byte has gone out, the second byte follows in the next cycle without waiting.

Top module: `mehp_host_port`

## Requirements
- R1: A reset with `en` low leaves the block idle: `req`, `wr_en` and `done` all read 0 in the first cycle after reset is released.
- R2: A reset with `en` high enters load mode, and `req` reads 1 in the first cycle after reset is released.
- R3: In load mode a byte is stored only at a clock edge where `gnt` and `byte_vld` are both 1. While loading, `wr_en` stays 0 and the block does not drive the data or address lanes.
- R4: The store location is word `addr_io[10:1]`. An even byte address (bit 0 = 0) fills instruction bits 7:0, and an odd one fills bits 15:8. Address bits 19:11 are ignored.
- R5: The edge that stores byte address 2047 ends load mode: `req` reads 0 in the next cycle, and later byte-valid cycles change no stored instruction.
- R6: A one-cycle `mv_vld` pulse while idle latches `mv_x`/`mv_y` and raises `req`. At the first edge with `gnt` high, `data_io` = x and `addr_io` = `RES_BASE` (default 20'hFFFF0) for one cycle. The next cycle shows `data_io` = y and `addr_io` = `RES_BASE`+1. `wr_en` is 1 in exactly those two cycles.
- R7: `done` inverts at the edge that places each result byte and at no other edge after reset.
- R8: `req` drops in the cycle after the vertical byte is on the lane, and stays high from the `mv_vld` pulse until then.
- R9: `mv_vld` is ignored unless the block is idle, both during load mode and during a result transfer.
- R10: `instr_rdata` returns the instruction at `instr_raddr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Selects load mode when high together with `rst` |
| req | output | 1 | Bus ownership request to the arbiter |
| gnt | input | 1 | Bus grant from the arbiter |
| wr_en | output | 1 | High while the block drives a result byte (write), low for read/idle |
| addr_io | inout | 20 | Address lane: host byte address during load, result address during output |
| data_io | inout | 8 | Data lane: load bytes in, result bytes out |
| byte_vld | input | 1 | Host marks a valid load byte on the lanes |
| mv_vld | input | 1 | Core pulses when a motion vector is ready |
| mv_x | input | 8 | Horizontal vector component |
| mv_y | input | 8 | Vertical vector component |
| done | output | 1 | Inverts with each result byte placed on the data lane |
| instr_raddr | input | 10 | Instruction word address from the core |
| instr_rdata | output | 16 | Instruction word, one cycle after the address |

## Verification
Two functions can collide in one cycle. The final load byte, at address 2047, can arrive in the same cycle as a result pulse from the core. The bench provokes this by raising `mv_vld` on that final load edge. It then judges the outcome at the ports. The load must close, with `req` low in the next cycle. The pulse must be dropped, so no request is raised, `wr_en` stays low and `done` keeps its value. The last instruction word must still hold the byte written on that edge.

// File: rtl/mehp_pkg.sv
package mehp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_WAIT = 3'd2,
    ST_XOUT = 3'd3,
    ST_YOUT = 3'd4
  } port_state_e;

endpackage

// File: rtl/mehp_prog_ram.sv
module mehp_prog_ram #(
  parameter int DATA_W  = 8,
  parameter int INSTR_W = 16,
  parameter int WORDS   = 1024,
  localparam int LANES  = INSTR_W / DATA_W,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WA_W   = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WA_W-1:0]    waddr,
  input  logic [LANE_W-1:0]  lane,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [WA_W-1:0]    raddr,
  output logic [INSTR_W-1:0] rdata
);

  logic [INSTR_W-1:0] mem [WORDS];
  logic [LANES-1:0]   lane_we;

  always_comb begin
    lane_we = '0;
    if (we) lane_we[lane] = 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[waddr][g*DATA_W +: DATA_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

  AST_ONE_LANE: assert property (@(posedge clk) $onehot0(lane_we)); // R4

endmodule

// File: rtl/mehp_ctrl.sv
module mehp_ctrl
  import mehp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              gnt,
  input  logic              byte_vld,
  input  logic              load_last,
  input  logic              mv_vld,
  input  logic [DATA_W-1:0] mv_x,
  input  logic [DATA_W-1:0] mv_y,
  output logic              req,
  output logic              wr_en,
  output logic              sel_y,
  output logic [DATA_W-1:0] out_byte,
  output logic              done,
  output logic              load_we
);

  port_state_e       state_q;
  logic [DATA_W-1:0] x_q, y_q;
  logic              done_q;

  assign load_we  = (state_q == ST_LOAD) && gnt && byte_vld;
  assign req      = (state_q != ST_IDLE);
  assign wr_en    = (state_q == ST_XOUT) || (state_q == ST_YOUT);
  assign sel_y    = (state_q == ST_YOUT);
  assign out_byte = sel_y ? y_q : x_q;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= en ? ST_LOAD : ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (mv_vld) begin
          x_q     <= mv_x;
          y_q     <= mv_y;
          state_q <= ST_WAIT;
        end
        ST_LOAD: if (load_we && load_last) state_q <= ST_IDLE;
        ST_WAIT: if (gnt) begin
          state_q <= ST_XOUT;
          done_q  <= ~done_q;
        end
        ST_XOUT: begin
          state_q <= ST_YOUT;
          done_q  <= ~done_q;
        end
        ST_YOUT: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_X_THEN_Y: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XOUT) |=> (state_q == ST_YOUT)); // R6
  AST_WR_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> req); // R6
  AST_DONE_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (done_q != $past(done_q))) |-> wr_en); // R7
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_YOUT) |=> !req); // R8
  AST_LOAD_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    load_we |-> !wr_en); // R3
  AST_LOAD_IGNORES_MV: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_LOAD) && !(load_we && load_last)) |=> (state_q == ST_LOAD)); // R9

endmodule

// File: rtl/mehp_host_port.sv
module mehp_host_port #(
  parameter int               ADDR_W     = 20,
  parameter int               DATA_W     = 8,
  parameter int               INSTR_W    = 16,
  parameter int               PROG_BYTES = 2048,
  parameter logic [ADDR_W-1:0] RES_BASE  = 20'hFFFF0,
  localparam int LANES  = INSTR_W / DATA_W,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WORDS  = PROG_BYTES / LANES,
  localparam int WA_W   = $clog2(WORDS),
  localparam int PA_W   = $clog2(PROG_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  output logic               req,
  input  logic               gnt,
  output logic               wr_en,
  inout  wire  [ADDR_W-1:0]  addr_io,
  inout  wire  [DATA_W-1:0]  data_io,
  input  logic               byte_vld,
  input  logic               mv_vld,
  input  logic [DATA_W-1:0]  mv_x,
  input  logic [DATA_W-1:0]  mv_y,
  output logic               done,
  input  logic [WA_W-1:0]    instr_raddr,
  output logic [INSTR_W-1:0] instr_rdata
);

  logic              sel_y, load_we, load_last;
  logic [DATA_W-1:0] out_byte;
  logic [PA_W-1:0]   byte_addr;
  logic [ADDR_W-1:0] out_addr;
  logic              unused_hi_addr;

  assign byte_addr      = addr_io[PA_W-1:0];
  assign unused_hi_addr = ^addr_io[ADDR_W-1:PA_W];
  assign load_last      = &byte_addr;
  assign out_addr       = RES_BASE + {{(ADDR_W-1){1'b0}}, sel_y};

  assign data_io = wr_en ? out_byte : {DATA_W{1'bz}};
  assign addr_io = wr_en ? out_addr : {ADDR_W{1'bz}};

  mehp_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst), .en(en), .gnt(gnt), .byte_vld(byte_vld),
    .load_last(load_last), .mv_vld(mv_vld), .mv_x(mv_x), .mv_y(mv_y),
    .req(req), .wr_en(wr_en), .sel_y(sel_y), .out_byte(out_byte),
    .done(done), .load_we(load_we)
  );

  mehp_prog_ram #(.DATA_W(DATA_W), .INSTR_W(INSTR_W), .WORDS(WORDS)) ram_i (
    .clk(clk), .we(load_we),
    .waddr(byte_addr[PA_W-1:LANE_W]), .lane(byte_addr[LANE_W-1:0]),
    .wdata(data_io), .raddr(instr_raddr), .rdata(instr_rdata)
  );

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (req && !wr_en && !load_we) |=> req); // R8

endmodule

// File: tb/mehp_host_port_tb_top.sv
module mehp_host_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] RES_BASE = 20'hFFFF0;
  // {x, y, grant delay, inject mv_vld during x byte}
  localparam int NVEC = 6;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h12, 8'h34, 4'd0, 4'd0},
    {8'hFF, 8'h00, 4'd1, 4'd0},
    {8'h80, 8'h7F, 4'd3, 4'd1},
    {8'hF9, 8'h07, 4'd0, 4'd1},
    {8'h00, 8'hFF, 4'd5, 4'd0},
    {8'hA5, 8'h5A, 4'd2, 4'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, gnt = 1'b0, byte_vld = 1'b0, mv_vld = 1'b0;
  logic [7:0] mv_x = '0, mv_y = '0;
  logic [9:0] instr_raddr = '0;
  logic req, wr_en, done;
  logic [15:0] instr_rdata;
  logic tb_drv = 1'b0;
  logic [7:0] tb_data = '0;
  logic [19:0] tb_addr = '0;
  wire [7:0] data_bus;
  wire [19:0] addr_bus;
  int n_run = 0, n_fail = 0;
  logic exp_done = 1'b0;
  logic finished = 1'b0;

  assign data_bus = tb_drv ? tb_data : 8'bz;
  assign addr_bus = tb_drv ? tb_addr : 20'bz;

  always #(CLK_PERIOD/2) clk = ~clk;

  mehp_host_port dut_i (
    .clk(clk), .rst(rst), .en(en), .req(req), .gnt(gnt), .wr_en(wr_en),
    .addr_io(addr_bus), .data_io(data_bus), .byte_vld(byte_vld),
    .mv_vld(mv_vld), .mv_x(mv_x), .mv_y(mv_y), .done(done),
    .instr_raddr(instr_raddr), .instr_rdata(instr_rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7) ^ (a >> 8));
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic rd_word(input int w, input logic [15:0] exp, input string tag);
    tick(); instr_raddr = 10'(w);
    tick();
    @(negedge clk);
    chk(instr_rdata == exp, tag, instr_rdata, exp);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1 reset without enable
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    chk(req == 1'b0, "R1 req", req, 0);
    chk(wr_en == 1'b0, "R1 wr_en", wr_en, 0);
    chk(done == 1'b0, "R1 done", done, 0);

    // Main readout table: R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] vx, vy;
      int dly;
      logic inj;
      vx = VEC[i][23:16]; vy = VEC[i][15:8];
      dly = int'(VEC[i][7:4]); inj = VEC[i][0];
      tick(); mv_x = vx; mv_y = vy; mv_vld = 1'b1; gnt = 1'b0;
      tick(); mv_vld = 1'b0; mv_x = ~vx; mv_y = ~vy;
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk(req && !wr_en, "R8 req held while waiting", {req, wr_en}, 2);
        chk(done == exp_done, "R7 done steady while waiting", done, exp_done);
        tick();
      end
      gnt = 1'b1;
      tick();
      if (inj) begin mv_vld = 1'b1; mv_x = 8'h3C; mv_y = 8'hC3; end
      exp_done = ~exp_done;
      @(negedge clk);
      chk(wr_en && data_bus == vx, "R6 x byte", data_bus, vx);
      chk(addr_bus == RES_BASE, "R6 x addr", addr_bus, RES_BASE);
      chk(done == exp_done, "R7 toggle x", done, exp_done);
      tick(); gnt = 1'b0; mv_vld = 1'b0;
      exp_done = ~exp_done;
      @(negedge clk);
      chk(wr_en && data_bus == vy, "R6 y byte", data_bus, vy);
      chk(addr_bus == RES_BASE + 20'd1, "R6 y addr", addr_bus, RES_BASE + 20'd1);
      chk(done == exp_done, "R7 toggle y", done, exp_done);
      tick();
      @(negedge clk);
      chk(!req && !wr_en, "R8 req released", {req, wr_en}, 0);
      if (inj) begin
        tick(); @(negedge clk);
        chk(!req && done == exp_done, "R9 mv_vld during output ignored", {req, done}, {1'b0, exp_done});
      end
    end

    // R2 load entry
    tick(); rst = 1'b1; en = 1'b1;
    tick(); rst = 1'b0; en = 1'b0;
    exp_done = 1'b0;
    @(negedge clk);
    chk(req == 1'b1, "R2 load mode req", req, 1);
    chk(done == 1'b0, "R2 done cleared", done, 0);

    // R3: last address presented without grant, then without valid
    tb_drv = 1'b1; tb_addr = 20'h007FF; tb_data = 8'hEE;
    byte_vld = 1'b1; gnt = 1'b0;
    tick(); tick();
    @(negedge clk);
    chk(req == 1'b1, "R3 no store without gnt", req, 1);
    byte_vld = 1'b0; gnt = 1'b1;
    tick(); tick();
    @(negedge clk);
    chk(req == 1'b1 && wr_en == 1'b0, "R3 no store without byte_vld", {req, wr_en}, 2);

    // Fill all bytes; R4 upper address bits vary; R9 mv_vld with final byte
    for (int a = 0; a < 2048; a++) begin
      tick();
      tb_addr = {9'(a * 37), 11'(a)};
      tb_data = pat(a);
      byte_vld = 1'b1;
      mv_vld = (a == 2047);
      mv_x = 8'h99; mv_y = 8'h66;
      if (a < 2047) begin
        @(negedge clk);
        if (a == 1000) chk(req == 1'b1 && wr_en == 1'b0, "R3 loading no drive", {req, wr_en}, 2);
      end
    end
    tick(); mv_vld = 1'b0; byte_vld = 1'b0;
    @(negedge clk);
    chk(req == 1'b0, "R5 load closes after 2047", req, 0);
    chk(done == 1'b0, "R9 mv_vld on final load edge dropped", done, 0);
    tick(); @(negedge clk);
    chk(!req && !wr_en, "R9 no result request", {req, wr_en}, 0);

    // R5: later byte writes ignored
    tb_addr = 20'h00000; tb_data = 8'h55; byte_vld = 1'b1;
    tick(); tick(); byte_vld = 1'b0; tb_drv = 1'b0;

    rd_word(0, {pat(1), pat(0)}, "R5 word0 unchanged / R4 lanes");
    rd_word(1, {pat(3), pat(2)}, "R4 word1");
    rd_word(511, {pat(1023), pat(1022)}, "R10 word511");
    rd_word(1023, {pat(2047), pat(2046)}, "R4 word1023 final byte kept");
    rd_word(700, {pat(1401), pat(1400)}, "R10 word700");

    // R10 one-cycle latency: change address, data must not change before the edge
    tick(); instr_raddr = 10'd2;
    @(negedge clk);
    chk(instr_rdata == {pat(1401), pat(1400)}, "R10 latency hold", instr_rdata, {pat(1401), pat(1400)});
    tick(); @(negedge clk);
    chk(instr_rdata == {pat(5), pat(4)}, "R10 latency update", instr_rdata, {pat(5), pat(4)});

    finish_run();
  end

endmodule